// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between an on-chip request port and an external 32K x 8 asynchronous static RAM. It takes one word per request, read or write, through a valid/ready handshake, and turns it into a timed sequence of the RAM's active-low select, write and output-enable strobes. On the RAM side it drives a 15-bit address and splits the shared 8-bit data bus into a driven value, a driver enable and a sampled input.

All timing is counted in clock cycles. Each phase length is the ceiling of a nanosecond limit divided by the clock period. The limits are read access time, write pulse width, data setup, bus release time and write cycle time, and the ceiling is never less than one cycle. A read returns its word on a one-cycle response pulse. A write gives no response. A new request is accepted on the cycle after the previous one finishes.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1, `mem_sel_n`, `mem_wr_n` and `mem_rd_n` are 1, `mem_dq_en` is 0 and `rsp_valid` is 0.
- R2: A read accepted on clock edge A drives `mem_sel_n`=0, `mem_rd_n`=0 and `mem_wr_n`=1 from edge A. It samples `mem_dq_in` on edge A+T_AA. It raises `rsp_valid` for exactly one cycle after that edge, with `rsp_data` holding the word last written to that address.
- R3: A write accepted on edge A drives `mem_sel_n`=0, `mem_wr_n`=0 and `mem_rd_n`=1 from edge A. The RAM stores the driven byte when the strobes end the write.
- R4: `mem_dq_en` is never 1 while `mem_rd_n` is 0. It first goes to 1 only after `mem_wr_n` has been low for T_HZ cycles.
- R5: `mem_wr_n` stays low for at least T_PWE cycles. The write byte is driven unchanged for at least T_SD cycles before the write ends.
- R6: `mem_sel_n` and `mem_wr_n` rise on the same edge. The driver stays on, with the same byte, for one cycle after that edge and is then off.
- R7: `req_ready` is 0 from the accept edge until the operation completes. The gap between back-to-back accepts is T_AA+2 cycles after a read and T_HZ+P+H+1 cycles after a write. Here P=max(T_SD, T_PWE-T_HZ, 1) and H=max(1, T_WC-T_HZ-P).
- R8: All 15 address bits reach the RAM, so address 0 and address 0x7FFF hold separate words.
- R9: The cycle counts are T_x = max(1, ceil(x_NS / CLK_NS)). With the defaults (10 ns clock; 12, 8, 8, 7 and 12 ns limits) this gives T_AA=2, T_PWE=1, T_SD=1, T_HZ=1 and T_WC=2, so both read and write gaps are 4 cycles.
- R10: A write never produces a `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_data | output | 8 | Read byte |
| mem_addr | output | 15 | RAM address |
| mem_sel_n | output | 1 | RAM chip select, active low |
| mem_wr_n | output | 1 | RAM write strobe, active low |
| mem_rd_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_en | output | 1 | Data bus driver enable |
| mem_dq_in | input | 8 | Byte sampled from the data bus |

## Verification
The assertions assume that the RAM behaves within its stated limits. It must present valid data no later than the read access time after the strobes settle, and it must release the bus within the release time after output enable rises or write enable falls. They also assume that `req_addr` and `req_wdata` are only looked at on the accept edge. The bench's RAM model holds `mem_dq_in` at a poison value until the read strobes have been steady for exactly T_AA negative edges, so an early capture reads poison. The model also reports any cycle in which the controller drives while the RAM would be driving. The driver changes request fields only at negative edges.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_RD_RET,
    ST_WR_RELEASE,
    ST_WR_DRIVE,
    ST_WR_TAIL
  } ctrl_state_e;

  // ceiling of ns / clk_ns, never below one cycle
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // a running phase counts down by one each cycle
  p_count_down_r7: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1))
    else $error("phase counter skipped");
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cap_en;
      if (cap_en) rsp_data <= dq_in;
    end
  end

  p_rsp_single_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid)
    else $error("response longer than one cycle");
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int CLK_NS = 10,
  parameter int AA_NS  = 12,
  parameter int PWE_NS = 8,
  parameter int SD_NS  = 8,
  parameter int HZ_NS  = 7,
  parameter int WC_NS  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_wr_n,
  output logic              mem_rd_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_en,
  input  logic [DATA_W-1:0] mem_dq_in
);
  import sram_ctrl_pkg::*;

  localparam int T_AA  = ns_to_cyc(AA_NS,  CLK_NS);
  localparam int T_PWE = ns_to_cyc(PWE_NS, CLK_NS);
  localparam int T_SD  = ns_to_cyc(SD_NS,  CLK_NS);
  localparam int T_HZ  = ns_to_cyc(HZ_NS,  CLK_NS);
  localparam int T_WC  = ns_to_cyc(WC_NS,  CLK_NS);
  localparam int P_A   = (T_PWE - T_HZ > 1) ? (T_PWE - T_HZ) : 1;
  localparam int T_PUL = (T_SD > P_A) ? T_SD : P_A;
  localparam int T_HLD = (T_WC - T_HZ - T_PUL > 1) ? (T_WC - T_HZ - T_PUL) : 1;
  localparam int CNT_W = $clog2(T_AA + T_HZ + T_PUL + T_HLD + 1);

  ctrl_state_e state_q;
  logic [DATA_W-1:0] wdata_q;
  logic              expired;
  logic              cnt_load;
  logic [CNT_W-1:0]  cnt_val;
  logic              cap_en;

  // phase lengths loaded on each state entry
  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        cnt_load = 1'b1;
        cnt_val  = req_we ? CNT_W'(T_HZ - 1) : CNT_W'(T_AA - 1);
      end
      ST_WR_RELEASE: if (expired) begin
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(T_PUL - 1);
      end
      ST_WR_DRIVE: if (expired) begin
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(T_HLD - 1);
      end
      default: ;
    endcase
  end

  assign cap_en    = (state_q == ST_RD_WAIT) && expired;
  assign req_ready = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      mem_addr   <= '0;
      wdata_q    <= '0;
      mem_sel_n  <= 1'b1;
      mem_wr_n   <= 1'b1;
      mem_rd_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_en  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          mem_addr  <= req_addr;
          wdata_q   <= req_wdata;
          mem_sel_n <= 1'b0;
          if (req_we) begin
            mem_wr_n <= 1'b0;
            state_q  <= ST_WR_RELEASE;
          end else begin
            mem_rd_n <= 1'b0;
            state_q  <= ST_RD_WAIT;
          end
        end
        ST_RD_WAIT: if (expired) begin
          mem_sel_n <= 1'b1;
          mem_rd_n  <= 1'b1;
          state_q   <= ST_RD_RET;
        end
        ST_RD_RET: state_q <= ST_IDLE;
        ST_WR_RELEASE: if (expired) begin
          mem_dq_out <= wdata_q;
          mem_dq_en  <= 1'b1;
          state_q    <= ST_WR_DRIVE;
        end
        ST_WR_DRIVE: if (expired) begin
          mem_wr_n  <= 1'b1;
          mem_sel_n <= 1'b1;
          state_q   <= ST_WR_TAIL;
        end
        ST_WR_TAIL: begin
          mem_dq_en <= 1'b0;
          if (expired) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sram_phase_cnt #(.W(CNT_W)) u_phase (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .expired(expired)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .cap_en(cap_en), .dq_in(mem_dq_in),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  p_no_drive_on_read_r4: assert property (@(posedge clk) disable iff (rst)
    mem_dq_en |-> mem_rd_n)
    else $error("driver on while RAM output enabled");

  p_drive_after_release_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_en) |-> (!mem_wr_n && !$past(mem_wr_n)))
    else $error("driver on before bus release");

  p_wr_needs_sel_r6: assert property (@(posedge clk) disable iff (rst)
    !mem_wr_n |-> !mem_sel_n)
    else $error("write strobe without select");

  p_hold_after_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr_n) |-> (mem_dq_en && $stable(mem_dq_out)))
    else $error("data not held after write end");

  p_read_strobes_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_we) |=> (!mem_sel_n && !mem_rd_n && mem_wr_n))
    else $error("read strobes wrong");

  p_write_strobes_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_we) |=> (!mem_sel_n && !mem_wr_n && mem_rd_n))
    else $error("write strobes wrong");

  p_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready)
    else $error("ready high right after accept");

  p_no_wr_rsp_r10: assert property (@(posedge clk) disable iff (rst)
    (!mem_wr_n) |=> !rsp_valid)
    else $error("response during write");
endmodule

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int B_AA  = (12 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int B_PWE = (8  + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int B_SD  = (8  + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int B_HZ  = (7  + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int B_WC  = (12 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int B_PA  = (B_PWE - B_HZ > 1) ? B_PWE - B_HZ : 1;
  localparam int B_P   = (B_SD > B_PA) ? B_SD : B_PA;
  localparam int B_H   = (B_WC - B_HZ - B_P > 1) ? B_WC - B_HZ - B_P : 1;
  localparam int RD_GAP = B_AA + 2;
  localparam int WR_GAP = B_HZ + B_P + B_H + 1;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_we = 0;
  logic req_ready;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic rsp_valid;
  logic [7:0] rsp_data;
  logic [14:0] mem_addr;
  logic mem_sel_n, mem_wr_n, mem_rd_n, mem_dq_en;
  logic [7:0] mem_dq_out;
  logic [7:0] mem_dq_in = 8'hEE;

  int cyc = 0, n_chk = 0, n_fail = 0;

  sram_ctrl u_sram_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n),
    .mem_dq_out(mem_dq_out), .mem_dq_en(mem_dq_en), .mem_dq_in(mem_dq_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // RAM model with access delay and write on strobe release
  logic [7:0] ram [logic [14:0]];
  int rd_cnt = 0, wlow = 0, drv = 0;
  bit prev_wr = 0, hold_pend = 0;
  logic [7:0]  last_d = '0;
  logic [14:0] last_a = '0, waddr = '0;

  always @(negedge clk) begin
    if (rst) begin
      rd_cnt = 0; wlow = 0; drv = 0; prev_wr = 0; hold_pend = 0;
      mem_dq_in = 8'hEE;
    end else begin
      bit rd_act, wr_act;
      rd_act = !mem_sel_n && !mem_rd_n && mem_wr_n;
      wr_act = !mem_sel_n && !mem_wr_n;
      if (rd_act && rd_cnt > 0 && mem_addr == last_a) rd_cnt++;
      else rd_cnt = rd_act ? 1 : 0;
      last_a = mem_addr;
      mem_dq_in = (rd_cnt >= B_AA && ram.exists(mem_addr)) ? ram[mem_addr] : 8'hEE;
      if (mem_dq_en && !mem_rd_n) chk(0, "R4 bus contention", 1, 0);
      if (wr_act) begin
        wlow++;
        waddr = mem_addr;
        if (mem_dq_en) begin
          if (drv == 0) chk(wlow >= B_HZ + 1, "R4 driver before release", wlow, B_HZ + 1);
          if (drv > 0 && mem_dq_out != last_d) drv = 1; else drv++;
          last_d = mem_dq_out;
        end
      end else if (prev_wr) begin
        chk(wlow >= B_PWE, "R5 write pulse cycles", wlow, B_PWE);
        chk(drv >= B_SD, "R5 data setup cycles", drv, B_SD);
        chk(mem_sel_n && mem_wr_n, "R6 select and write rise together", {mem_sel_n, mem_wr_n}, 3);
        chk(mem_dq_en && mem_dq_out == last_d, "R6 data held after end", mem_dq_out, last_d);
        ram[waddr] = last_d;
        hold_pend = 1; wlow = 0; drv = 0;
      end else if (hold_pend) begin
        chk(!mem_dq_en, "R6 driver off after hold", mem_dq_en, 0);
        hold_pend = 0;
      end
      prev_wr = wr_act;
    end
  end

  // scoreboard
  logic [7:0] exp_q[$];
  int cyc_q[$];
  logic [7:0] ref_mem [logic [14:0]];
  bit prev_rsp = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid) begin
        chk(!prev_rsp, "R2 single-cycle response", 1, 0);
        if (exp_q.size() == 0) chk(0, "R10 unexpected response", rsp_data, 0);
        else begin
          logic [7:0] e;
          int c;
          e = exp_q.pop_front();
          c = cyc_q.pop_front();
          chk(rsp_data == e, "R2 read data", rsp_data, e);
          chk(cyc == c + B_AA, "R2 response cycle", cyc, c + B_AA);
        end
      end
      prev_rsp = rsp_valid;
    end
  end

  task automatic issue(input bit we, input logic [14:0] a, input logic [7:0] d);
    int acc, k;
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    acc = cyc;
    req_valid = 0;
    if (we) begin
      ref_mem[a] = d;
      chk(!mem_sel_n && !mem_wr_n && mem_rd_n, "R3 write strobes",
          {mem_sel_n, mem_wr_n, mem_rd_n}, 1);
    end else begin
      exp_q.push_back(ref_mem.exists(a) ? ref_mem[a] : 8'hEE);
      cyc_q.push_back(acc);
      chk(!mem_sel_n && !mem_rd_n && mem_wr_n, "R2 read strobes",
          {mem_sel_n, mem_wr_n, mem_rd_n}, 2);
    end
    k = 0;
    while (!req_ready) begin @(negedge clk); k++; end
    chk(k == (we ? WR_GAP : RD_GAP) - 1, we ? "R7 R9 write busy cycles" : "R7 R9 read busy cycles",
        k, (we ? WR_GAP : RD_GAP) - 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1, "R1 ready in reset", req_ready, 1);
    chk(mem_sel_n && mem_wr_n && mem_rd_n, "R1 strobes idle", {mem_sel_n, mem_wr_n, mem_rd_n}, 7);
    chk(!mem_dq_en, "R1 driver off", mem_dq_en, 0);
    chk(!rsp_valid, "R1 no response", rsp_valid, 0);
    rst = 0;
    @(negedge clk);
    chk(req_ready && mem_sel_n && !mem_dq_en, "R1 idle after reset", req_ready, 1);
    // R8: address extremes
    issue(1, 15'h0000, 8'h5A);
    issue(1, 15'h7FFF, 8'hA5);
    issue(0, 15'h0000, 8'h00);
    issue(0, 15'h7FFF, 8'h00);
    // back-to-back mixed patterns
    for (int i = 0; i < 16; i++) issue(1, 15'(i * 2053 + 7), 8'(i * 37 + 1));
    for (int i = 15; i >= 0; i--) issue(0, 15'(i * 2053 + 7), 8'h00);
    for (int i = 0; i < 8; i++) begin
      issue(1, 15'(i + 300), 8'(8'hF0 ^ i));
      issue(0, 15'(i + 300), 8'h00);
      issue(0, 15'h7FFF, 8'h00);
    end
    issue(1, 15'h0000, 8'hFF);
    issue(1, 15'h0000, 8'h00);
    issue(0, 15'h0000, 8'h00);
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all responses returned", exp_q.size(), 0);
    chk(!rsp_valid && req_ready, "R10 quiet after writes", rsp_valid, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    chk(0, "R7 watchdog expired", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule